// File: doc/BRIEF.md
# Hit Event Memory with Roll Mode

This block collects one record per trigger from a 64-channel front end. A record packs an 8-bit header, a 24-bit bunch-crossing identifier and a 2-bit discriminator code for every channel, 160 bits in all. The store holds 128 records. The acquisition sequencer raises a trigger to capture the record presented on the inputs. It watches a full flag to decide when to stop acquiring. It then requests a readout, and the block shifts every stored record out serially, oldest first.

A configuration input selects between two modes. In fill-once mode (`roll_mode` = 0), the first 128 records are kept and later triggers are discarded. In circular mode (`roll_mode` = 1), new records overwrite the oldest ones, so the last 128 survive. The readout start address follows the mode. In circular mode, once the store is full, readout starts at the write pointer. In every other case it starts at address 0.

A single state machine controls the block and has four states. ST_ACQ accepts triggers. A readout request in ST_ACQ moves to ST_LOAD, or straight to ST_DONE when nothing is stored. ST_LOAD copies one record into the shifter and always moves to ST_SHIFT. ST_SHIFT emits 160 bits. After the last bit it returns to ST_LOAD if more records remain, and otherwise moves to ST_DONE. ST_DONE raises the end-of-readout pulse for one cycle and returns to ST_ACQ.

Top module: `hit_event_mem`

## Requirements
- R1: A synchronous reset (`rst` high) clears the write pointer, the record count and `mem_full`. While in reset and in the first cycle after it, `dout_valid` and `rd_done` are low. Reset does not clear the record storage.
- R2: In ST_ACQ, a cycle with `trig` high and `rd_req` low stores the record {`hdr_in`, `bcid_in`, `hits_in`} at the write pointer and advances the pointer. The count rises by one unless it is already 128. Channel c's code is `hits_in[2c+1:2c]`.
- R3: With `roll_mode` = 0 and 128 records stored, further triggers are ignored, and a readout returns the first 128 records captured.
- R4: With `roll_mode` = 1, triggers always store and the pointer wraps from 127 to 0. Readout returns the last min(N,128) records captured, oldest first, starting at the write pointer once the store is full and at address 0 before that.
- R5: `mem_full` goes high in the cycle after the count reaches 128 and stays high until reset.
- R6: A readout emits exactly as many records as the count. Each record is 160 bits sent MSB first: header bit 7 first, then bunch-crossing ID bit 23 down to 0, then `hits_in` bit 127 down to 0. `dout_valid` is high for each bit and low otherwise.
- R7: `rd_done` is a one-cycle pulse in the cycle after the last bit. With a count of zero, it pulses in the cycle after the request and no bits are sent.
- R8: A trigger in the same cycle as a readout request is dropped. Triggers are also ignored from then until `rd_done` has been seen.
- R9: A readout does not change the stored records, the count or `mem_full`, so a second readout repeats the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| roll_mode | input | 1 | 0: fill-once, 1: circular overwrite |
| trig | input | 1 | Capture the presented record |
| hdr_in | input | 8 | Record header |
| bcid_in | input | 24 | Bunch-crossing identifier |
| hits_in | input | 128 | 2-bit code per channel, channel c at [2c+1:2c] |
| rd_req | input | 1 | Start a readout of all stored records |
| mem_full | output | 1 | 128 records held |
| dout | output | 1 | Serial record data, MSB first |
| dout_valid | output | 1 | `dout` carries a record bit |
| rd_done | output | 1 | End-of-readout pulse |

## Verification
A trigger and a readout request can arrive in the same ST_ACQ cycle, and the request takes priority. The bench provokes this by raising both together and holding the trigger high through the whole readout. It then judges the result with a second readout, which must return the identical record list with an unchanged count. Separately, the circular-mode start address is checked by comparing a wrapped readout against a model that keeps only the newest 128 records.

// File: rtl/hitmem_pkg.sv
package hitmem_pkg;
    typedef enum logic [1:0] {
        ST_ACQ,
        ST_LOAD,
        ST_SHIFT,
        ST_DONE
    } hm_state_t;
endpackage

// File: rtl/hitmem_wr_track.sv
module hitmem_wr_track #(
    parameter int DEPTH = 128,
    parameter int AW    = $clog2(DEPTH),
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             roll_mode,
    input  logic             wr_try,
    output logic             wr_en,
    output logic [AW-1:0]    wr_ptr,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic [AW-1:0]    rd_start
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
    localparam logic [AW-1:0]    PTR_MAX = AW'(DEPTH - 1);

    assign full     = (count == CNT_MAX);
    assign wr_en    = wr_try && (roll_mode || !full);
    // oldest surviving entry sits at the write pointer only after a wrap
    assign rd_start = (roll_mode && full) ? wr_ptr : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            count  <= '0;
        end else if (wr_en) begin
            wr_ptr <= (wr_ptr == PTR_MAX) ? '0 : wr_ptr + 1'b1;
            if (!full) begin
                count <= count + 1'b1;
            end
        end
    end
endmodule

// File: rtl/hitmem_ram.sv
module hitmem_ram #(
    parameter int REC_W = 160,
    parameter int DEPTH = 128,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [REC_W-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [REC_W-1:0] rdata
);
    logic [REC_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/hit_event_mem.sv
module hit_event_mem
    import hitmem_pkg::*;
#(
    parameter int CHANNELS = 64,
    parameter int CODE_W   = 2,
    parameter int BCID_W   = 24,
    parameter int HDR_W    = 8,
    parameter int DEPTH    = 128
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         roll_mode,
    input  logic                         trig,
    input  logic [HDR_W-1:0]             hdr_in,
    input  logic [BCID_W-1:0]            bcid_in,
    input  logic [CHANNELS*CODE_W-1:0]   hits_in,
    input  logic                         rd_req,
    output logic                         mem_full,
    output logic                         dout,
    output logic                         dout_valid,
    output logic                         rd_done
);
    localparam int HIT_W = CHANNELS * CODE_W;
    localparam int REC_W = HDR_W + BCID_W + HIT_W;
    localparam int AW    = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int BW    = $clog2(REC_W);
    localparam logic [BW-1:0] LAST_BIT = BW'(REC_W - 1);
    localparam logic [AW-1:0] PTR_MAX  = AW'(DEPTH - 1);

    hm_state_t state, state_nx;

    logic             wr_try, wr_en;
    logic [AW-1:0]    wr_ptr, rd_start, rd_addr;
    logic [CNT_W-1:0] count, remaining;
    logic [BW-1:0]    bitcnt;
    logic [REC_W-1:0] ram_q, shreg, rec_in;
    logic             last_bit;

    assign rec_in   = {hdr_in, bcid_in, hits_in};
    assign wr_try   = (state == ST_ACQ) && trig && !rd_req;
    assign last_bit = (bitcnt == LAST_BIT);

    hitmem_wr_track #(
        .DEPTH (DEPTH),
        .AW    (AW),
        .CNT_W (CNT_W)
    ) u_track (
        .clk       (clk),
        .rst       (rst),
        .roll_mode (roll_mode),
        .wr_try    (wr_try),
        .wr_en     (wr_en),
        .wr_ptr    (wr_ptr),
        .count     (count),
        .full      (mem_full),
        .rd_start  (rd_start)
    );

    hitmem_ram #(
        .REC_W (REC_W),
        .DEPTH (DEPTH),
        .AW    (AW)
    ) u_ram (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_ptr),
        .wdata (rec_in),
        .raddr (rd_addr),
        .rdata (ram_q)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_ACQ;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_ACQ: begin
                if (rd_req) begin
                    state_nx = (count == '0) ? ST_DONE : ST_LOAD;
                end
            end
            ST_LOAD:  state_nx = ST_SHIFT;
            ST_SHIFT: begin
                if (last_bit) begin
                    state_nx = (remaining == CNT_W'(1)) ? ST_DONE : ST_LOAD;
                end
            end
            ST_DONE:  state_nx = ST_ACQ;
        endcase
    end

    // readout datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_addr   <= '0;
            remaining <= '0;
            bitcnt    <= '0;
            shreg     <= '0;
        end else begin
            unique case (state)
                ST_ACQ: begin
                    if (rd_req) begin
                        rd_addr   <= rd_start;
                        remaining <= count;
                    end
                end
                ST_LOAD: begin
                    shreg  <= ram_q;
                    bitcnt <= '0;
                end
                ST_SHIFT: begin
                    shreg  <= {shreg[REC_W-2:0], 1'b0};
                    bitcnt <= bitcnt + 1'b1;
                    if (last_bit) begin
                        rd_addr   <= (rd_addr == PTR_MAX) ? '0 : rd_addr + 1'b1;
                        remaining <= remaining - 1'b1;
                    end
                end
                ST_DONE: begin
                    bitcnt <= '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        dout       = 1'b0;
        dout_valid = 1'b0;
        rd_done    = 1'b0;
        unique case (state)
            ST_ACQ:   ;
            ST_LOAD:  ;
            ST_SHIFT: begin
                dout       = shreg[REC_W-1];
                dout_valid = 1'b1;
            end
            ST_DONE:  rd_done = 1'b1;
        endcase
    end
endmodule

// File: rtl/hit_event_mem_chk.sv
module hit_event_mem_chk #(
    parameter int DEPTH = 128,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             mem_full,
    input logic             dout_valid,
    input logic             rd_done,
    input logic [CNT_W-1:0] cnt
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!mem_full && !dout_valid && !rd_done));

    assert_step_one_R2: assert property (@(posedge clk) disable iff (rst)
        (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1));

    assert_full_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        mem_full |=> mem_full);

    assert_no_overlap_R6: assert property (@(posedge clk) disable iff (rst)
        !(rd_done && dout_valid));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        rd_done |=> !rd_done);

    assert_busy_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        dout_valid |=> (cnt == $past(cnt)));
endmodule

bind hit_event_mem hit_event_mem_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mem_full   (mem_full),
    .dout_valid (dout_valid),
    .rd_done    (rd_done),
    .cnt        (count)
);

// File: tb/hit_event_mem_test.sv
module hit_event_mem_test;
    localparam int DEPTH = 128;
    localparam int REC_W = 160;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         roll_mode = 1'b0;
    logic         trig = 1'b0;
    logic [7:0]   hdr_in = '0;
    logic [23:0]  bcid_in = '0;
    logic [127:0] hits_in = '0;
    logic         rd_req = 1'b0;
    logic         mem_full, dout, dout_valid, rd_done;

    always #10 clk = ~clk;

    hit_event_mem uut (
        .clk        (clk),
        .rst        (rst),
        .roll_mode  (roll_mode),
        .trig       (trig),
        .hdr_in     (hdr_in),
        .bcid_in    (bcid_in),
        .hits_in    (hits_in),
        .rd_req     (rd_req),
        .mem_full   (mem_full),
        .dout       (dout),
        .dout_valid (dout_valid),
        .rd_done    (rd_done)
    );

    int errors = 0;
    int checks = 0;
    logic [REC_W-1:0] model_mem [DEPTH];
    int model_wp = 0;
    int model_cnt = 0;
    logic [REC_W-1:0] exp_q [$];
    string cur_req = "";
    logic [REC_W-1:0] acc = '0;
    int nbits = 0;

    task automatic chk(string req, longint act, longint expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, expv);
        end
    endtask

    // monitor: assemble serial records and compare with the scoreboard
    always @(negedge clk) begin
        if (dout_valid) begin
            logic [REC_W-1:0] nxt;
            nxt = {acc[REC_W-2:0], dout};
            acc = nxt;
            nbits++;
            if (nbits == REC_W) begin
                nbits = 0;
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL %s: extra record %h, expected none", cur_req, nxt);
                end else begin
                    logic [REC_W-1:0] e;
                    e = exp_q.pop_front();
                    if (nxt !== e) begin
                        errors++;
                        $display("FAIL %s: record %h expected %h", cur_req, nxt, e);
                    end
                end
            end
        end
    end

    task automatic do_reset(bit roll);
        @(negedge clk);
        rst = 1'b1;
        roll_mode = roll;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_wp = 0;
        model_cnt = 0;
        chk("R1 mem_full after reset", mem_full, 0);
        chk("R1 dout_valid after reset", dout_valid, 0);
        chk("R1 rd_done after reset", rd_done, 0);
    endtask

    task automatic do_trig();
        logic [REC_W-1:0] rec;
        rec = {8'($urandom), 24'($urandom), $urandom, $urandom, $urandom, $urandom};
        @(negedge clk);
        trig = 1'b1;
        {hdr_in, bcid_in, hits_in} = rec;
        @(negedge clk);
        trig = 1'b0;
        if (roll_mode || model_cnt < DEPTH) begin
            model_mem[model_wp] = rec;
            model_wp = (model_wp + 1) % DEPTH;
            if (model_cnt < DEPTH) model_cnt++;
        end
    endtask

    task automatic do_readout(string req, bit hold_trig);
        int start;
        start = (roll_mode && model_cnt == DEPTH) ? model_wp : 0;
        for (int i = 0; i < model_cnt; i++) begin
            exp_q.push_back(model_mem[(start + i) % DEPTH]);
        end
        cur_req = req;
        @(negedge clk);
        rd_req = 1'b1;
        trig = hold_trig;
        @(negedge clk);
        rd_req = 1'b0;
        while (!rd_done) @(negedge clk);
        trig = 1'b0;
        chk({req, " R7 all records before rd_done"}, exp_q.size(), 0);
        chk({req, " R6 no partial record"}, nbits, 0);
        exp_q.delete();
        @(negedge clk);
        chk({req, " R7 rd_done one cycle"}, rd_done, 0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete, got timeout expected completion");
        finish_run();
    end

    initial begin
        // fill-once mode
        do_reset(1'b0);
        do_readout("R7 empty readout", 1'b0);
        repeat (5) do_trig();
        chk("R5 not full at 5", mem_full, 0);
        do_readout("R2 R6 five records", 1'b0);
        repeat (130) do_trig();
        chk("R5 full after 135 triggers", mem_full, 1);
        do_readout("R3 first 128 kept", 1'b0);
        do_readout("R9 repeat readout", 1'b0);
        chk("R9 full kept after readout", mem_full, 1);

        // circular mode
        do_reset(1'b1);
        repeat (10) do_trig();
        chk("R5 roll not full at 10", mem_full, 0);
        do_readout("R4 unwrapped start 0", 1'b0);
        repeat (190) do_trig();
        chk("R5 roll full", mem_full, 1);
        do_readout("R4 last 128 oldest first", 1'b0);

        // trigger and readout request together, trigger held through readout
        do_reset(1'b0);
        repeat (6) do_trig();
        do_readout("R8 collision readout", 1'b1);
        do_readout("R8 nothing added", 1'b1);
        chk("R8 not full after held trigger", mem_full, 0);

        finish_run();
    end
endmodule